// File: doc/BRIEF.md
# Two-Rank Shifting Register

This block is a 40-bit word register made of two ranks, an upper rank that forms the visible output and a lower rank that serves as a staging copy. Data never shifts inside a rank. Every movement is a gated copy from one rank to the other. A downward copy moves upper into lower unchanged. An upward copy brings lower back into upper, either displaced one place toward the most significant end or one place toward the least significant end. One shift step is therefore a down phase followed by an up phase, and each phase takes one clock.

A command port accepts four operations: parallel load of the upper rank, clear of both ranks, shift toward the MSB by N, and shift toward the LSB by N. For a shift, a 6-bit step counter is loaded with N (0 to 63) and counts down once per completed step. Vacated bit positions take the serial fill input as sampled in each up phase. Every accepted command ends with a one-cycle done pulse. While a shift runs, busy is high and new commands are dropped. A parallel machine uses the block to build its accumulator and quotient registers around an external sequencer.

Top module: `tworank_shifter`

## Requirements
- R1: After reset, upper_word is all zeros, busy is 0 and done is 0.
- R2: Operation code 0 (load) accepted while idle places load_word into upper_word after the accepting edge, and done is 1 for the following cycle.
- R3: Operation code 1 (clear) accepted while idle makes upper_word zero after the accepting edge, and done is 1 for the following cycle.
- R4: Operation code 2 with count N moves upper_word N places toward bit 39 and puts fill_bit into bit 0 at each step.
- R5: Operation code 3 with count N moves upper_word N places toward bit 0 and puts fill_bit into bit 39 at each step.
- R6: For a shift with N>0, busy is 1 from the cycle after acceptance, and busy falls with done rising exactly 2N clock edges after the accepting edge.
- R7: In a down phase the upper rank holds its value and the lower rank takes a copy of it. In an up phase the upper rank is fully replaced from the displaced lower rank, so no earlier upper bit survives.
- R8: A shift with count 0 leaves upper_word unchanged, keeps busy at 0 and pulses done in the next cycle.
- R9: A command presented while busy is 1 has no effect on the result, the shift length or the done timing.
- R10: Counts larger than the word width are honoured in full, so every bit then equals fill_bit, and the maximum count 63 takes 126 cycles.
- R11: done is high for exactly one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 load, 1 clear, 2 shift toward MSB, 3 shift toward LSB |
| cmd_count | input | 6 | Number of shift steps |
| load_word | input | 40 | Parallel data for the load operation |
| fill_bit | input | 1 | Serial value for vacated positions |
| busy | output | 1 | Shift in progress, commands ignored |
| done | output | 1 | One-cycle completion pulse |
| upper_word | output | 40 | Contents of the upper rank |

## Verification
The assertions check the phase discipline on every cycle. A down phase must leave the upper rank untouched and copy it into the lower rank. An up phase must leave the lower rank alone. The step counter must stay nonzero while busy, and busy may fall only together with done. Only the bench scenarios can show the end result of a whole shift against a reference. These scenarios cover both directions, fill values, counts of 0, 1, 40 and 63 with exact 2N timing, and commands injected mid-shift that must not disturb the outcome.

// File: rtl/tr_pkg.sv
package tr_pkg;
    localparam int WORD_W  = 40;
    localparam int COUNT_W = 6;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LEFT  = 2'd2,
        OP_RIGHT = 2'd3
    } tr_op_e;
endpackage

// File: rtl/tr_step_ctl.sv
module tr_step_ctl
    import tr_pkg::*;
#(
    parameter int COUNT_W = tr_pkg::COUNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [COUNT_W-1:0] cmd_count,
    output logic               load_en,
    output logic               clear_en,
    output logic               down_en,
    output logic               up_en,
    output logic               dir_left,
    output logic               busy,
    output logic               done
);
    typedef struct packed {
        logic               busy;
        logic               up_ph;
        logic               left;
        logic [COUNT_W-1:0] cnt;
        logic               done;
    } seq_t;

    localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

    seq_t s_d, s_q;
    logic accept_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        accept_d = cmd_valid && !s_q.busy;
        if (s_q.busy) begin
            if (!s_q.up_ph) begin
                s_d.up_ph = 1'b1;
            end else begin
                s_d.up_ph = 1'b0;
                s_d.cnt   = s_q.cnt - CNT_ONE;
                if (s_q.cnt == CNT_ONE) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end else if (cmd_valid) begin
            case (tr_op_e'(cmd_op))
                OP_LOAD, OP_CLEAR: s_d.done = 1'b1;
                default: begin
                    if (cmd_count == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.busy  = 1'b1;
                        s_d.up_ph = 1'b0;
                        s_d.left  = (tr_op_e'(cmd_op) == OP_LEFT);
                        s_d.cnt   = cmd_count;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign load_en  = accept_d && (tr_op_e'(cmd_op) == OP_LOAD);
    assign clear_en = accept_d && (tr_op_e'(cmd_op) == OP_CLEAR);
    assign down_en  = s_q.busy && !s_q.up_ph;
    assign up_en    = s_q.busy && s_q.up_ph;
    assign dir_left = s_q.left;
    assign busy     = s_q.busy;
    assign done     = s_q.done;

    // R6: a running shift always has steps left
    a_r6_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.cnt != '0));
    // R6: busy can only drop together with the done pulse
    a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> s_q.done);
    // R9: a down phase never ends the shift, whatever arrives on the command port
    a_r9_down_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.up_ph) |=> s_q.busy);
endmodule

// File: rtl/tr_rank_path.sv
module tr_rank_path #(
    parameter int WORD_W = tr_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              clear_en,
    input  logic              down_en,
    input  logic              up_en,
    input  logic              dir_left,
    input  logic              fill_bit,
    input  logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] upper_word
);
    typedef struct packed {
        logic [WORD_W-1:0] upper;
        logic [WORD_W-1:0] lower;
    } ranks_t;

    ranks_t r_d, r_q;
    logic [WORD_W-1:0] toward_msb, toward_lsb;

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign toward_msb[i] = fill_bit;
        end else begin : g_mid_l
            assign toward_msb[i] = r_q.lower[i-1];
        end
        if (i == WORD_W-1) begin : g_msb
            assign toward_lsb[i] = fill_bit;
        end else begin : g_mid_r
            assign toward_lsb[i] = r_q.lower[i+1];
        end
    end

    always_comb begin
        r_d = r_q;
        if (clear_en) begin
            r_d.upper = '0;
            r_d.lower = '0;
        end else if (load_en) begin
            r_d.upper = load_word;
        end else if (down_en) begin
            r_d.lower = r_q.upper;
        end else if (up_en) begin
            r_d.upper = dir_left ? toward_msb : toward_lsb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign upper_word = r_q.upper;

    // R7: the down phase leaves the upper rank alone
    a_r7_down_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        down_en |=> $stable(r_q.upper));
    // R7: the down phase copies upper into lower
    a_r7_lower_takes_upper: assert property (@(posedge clk) disable iff (!rst_n)
        down_en |=> (r_q.lower == $past(r_q.upper)));
    // R7: the up phase does not disturb the lower rank
    a_r7_up_keeps_lower: assert property (@(posedge clk) disable iff (!rst_n)
        up_en |=> $stable(r_q.lower));
endmodule

// File: rtl/tworank_shifter.sv
module tworank_shifter
    import tr_pkg::*;
#(
    parameter int WORD_W  = tr_pkg::WORD_W,
    parameter int COUNT_W = tr_pkg::COUNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [COUNT_W-1:0] cmd_count,
    input  logic [WORD_W-1:0]  load_word,
    input  logic               fill_bit,
    output logic               busy,
    output logic               done,
    output logic [WORD_W-1:0]  upper_word
);
    logic load_en, clear_en, down_en, up_en, dir_left;

    tr_step_ctl #(.COUNT_W(COUNT_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_count(cmd_count),
        .load_en  (load_en),
        .clear_en (clear_en),
        .down_en  (down_en),
        .up_en    (up_en),
        .dir_left (dir_left),
        .busy     (busy),
        .done     (done)
    );

    tr_rank_path #(.WORD_W(WORD_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .clear_en  (clear_en),
        .down_en   (down_en),
        .up_en     (up_en),
        .dir_left  (dir_left),
        .fill_bit  (fill_bit),
        .load_word (load_word),
        .upper_word(upper_word)
    );

    // R11: done never lasts into a cycle where a shift is still running
    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/tworank_shifter_tb.sv
module tworank_shifter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [5:0]  cmd_count = 6'd0;
    logic [39:0] load_word = '0;
    logic        fill_bit = 1'b0;
    logic        busy, done;
    logic [39:0] upper_word;

    int checks = 0;
    int errors = 0;
    logic [39:0] model = '0;

    always #4 clk = ~clk;

    tworank_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .load_word(load_word), .fill_bit(fill_bit),
        .busy(busy), .done(done), .upper_word(upper_word)
    );

    function automatic logic [39:0] ref_shift(logic [39:0] v, int n, bit left, bit f);
        for (int k = 0; k < n; k++)
            v = left ? {v[38:0], f} : {f, v[39:1]};
        return v;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one command; optionally inject a stray command mid-shift
    task automatic run(int op, int n, logic [39:0] data, bit f, bit inject, string req);
        int cyc;
        logic [39:0] exp;
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_count = 6'(n);
        load_word = data; fill_bit = f;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        load_word = ~data;
        case (op)
            0: exp = data;
            1: exp = '0;
            2: exp = ref_shift(model, n, 1'b1, f);
            default: exp = ref_shift(model, n, 1'b0, f);
        endcase
        if (op >= 2 && n > 0) begin
            check(busy === 1'b1 && done === 1'b0, req, {62'd0, busy, done}, 64'd2);
            cyc = 0;
            while (done !== 1'b1 && cyc < 200) begin
                if (inject && cyc == 1) begin
                    cmd_valid = 1'b1; cmd_op = 2'(cyc % 2); cmd_count = 6'd5;
                end
                @(posedge clk); @(negedge clk);
                cmd_valid = 1'b0;
                cyc++;
            end
            check(cyc == 2*n, "R6", 64'(cyc), 64'(2*n));
            check(busy === 1'b0, "R6", 64'(busy), 64'd0);
        end else begin
            check(done === 1'b1 && busy === 1'b0, req, {62'd0, busy, done}, 64'd1);
        end
        check(upper_word === exp, req, 64'(upper_word), 64'(exp));
        model = exp;
        @(posedge clk); @(negedge clk);
        check(done === 1'b0, "R11", 64'(done), 64'd0);
        check(upper_word === model, "R11", 64'(upper_word), 64'(model));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [39:0] pat;
        void'($urandom(32'd7731));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(upper_word === '0 && busy === 1'b0 && done === 1'b0, "R1",
              {23'd0, busy, done, upper_word[38:0]}, 64'd0);
        run(0, 0, 40'hA5_1234_5678, 1'b0, 1'b0, "R2");
        run(2, 1, '0, 1'b1, 1'b0, "R4");
        run(3, 1, '0, 1'b0, 1'b0, "R5");
        run(2, 0, '0, 1'b1, 1'b0, "R8");
        run(3, 0, '0, 1'b1, 1'b0, "R8");
        run(2, 7, '0, 1'b0, 1'b1, "R9");
        run(3, 9, '0, 1'b1, 1'b1, "R9");
        run(0, 0, 40'h80_0000_0001, 1'b0, 1'b0, "R2");
        run(3, 40, '0, 1'b1, 1'b0, "R10");
        run(0, 0, 40'h12_3456_789A, 1'b0, 1'b0, "R2");
        run(2, 63, '0, 1'b0, 1'b1, "R10");
        run(0, 0, 40'hFF_FFFF_FFFF, 1'b0, 1'b0, "R2");
        run(1, 0, '0, 1'b0, 1'b0, "R3");
        run(3, 2, '0, 1'b1, 1'b0, "R7");
        run(2, 2, '0, 1'b1, 1'b0, "R7");
        for (int it = 0; it < 40; it++) begin
            int op;
            int n;
            op = int'($urandom_range(0, 3));
            n = int'($urandom_range(0, 20));
            pat = {8'($urandom), 32'($urandom)};
            run(op, n, pat, 1'($urandom), 1'($urandom), op >= 2 ? (op == 2 ? "R4" : "R5") : (op == 0 ? "R2" : "R3"));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule